// File: doc/BRIEF.md
# UART Register Front End with Divisor Latch

This block is the bus-facing register set of a small UART. It holds the line-control byte, the 16-bit baud divisor, a transmit FIFO and a receive FIFO, and it decodes a simple single-cycle register bus. The serial shift engines sit outside. The transmit engine drains the transmit FIFO through a pop strobe, and the receive engine fills the receive FIFO through a push strobe.

One bus address, the data address, changes meaning with the divisor-latch-access bit, which is bit 7 of the line-control byte. With the bit set, the data address is the low byte of the baud divisor. With the bit clear, a write to it queues a byte for transmission and a read takes the oldest received byte. A second address gives the whole 16-bit divisor at any time. A status address reports the full and empty flags of both FIFOs. A push into a full FIFO is dropped without any sign, and so is a pop from an empty one.

Read data is registered. It appears on `rdata_o` one clock after the read strobe and holds until the next read.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line control, divisor and read data are 0. Both FIFOs are empty. A status read then returns 0x5.
- R2: When lcr bit 7 is 1, a write to the data address (word 0) loads wdata[7:0] into divisor[7:0] and leaves divisor[15:8] unchanged. A read of the data address returns divisor[7:0]. Neither FIFO is touched.
- R3: When lcr bit 7 is 0, a write to the data address pushes wdata[7:0] into the transmit FIFO. `tx_data_o` shows the oldest queued byte, and bytes leave in write order.
- R4: A data write while the transmit FIFO holds 8 bytes is dropped. The count and the contents of the FIFO stay unchanged.
- R5: When lcr bit 7 is 0, a read of the data address pops the receive FIFO exactly once. The popped byte appears in rdata[7:0] on the cycle after the strobe.
- R6: A data read with lcr bit 7 at 0 and an empty receive FIFO returns 0 and leaves the FIFO empty.
- R7: Write bits 31:8 are ignored on the data and line-control addresses. rdata[31:8] is 0 for every address except the divisor address.
- R8: The divisor address (word 2) reads and writes divisor[15:0] in bits 15:0 whatever the value of lcr bit 7. Bits 31:16 are ignored on write and read as 0.
- R9: The status address (word 3) reads bit0 = tx empty, bit1 = tx full, bit2 = rx empty and bit3 = rx full. All other bits read 0.
- R10: `tx_pop_i` on an empty transmit FIFO is ignored, and `rx_push_i` on a full receive FIFO is ignored. Ordering stays correct afterwards.
- R11: The line-control address (word 1) stores wdata[7:0] and reads it back. `lcr_o` carries the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address: 0 data, 1 line control, 2 divisor, 3 status |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Registered read data, valid the cycle after a read |
| tx_pop_i | input | 1 | Transmit engine takes the head byte |
| tx_data_o | output | DATA_W | Head of the transmit FIFO |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| tx_full_o | output | 1 | Transmit FIFO full |
| rx_push_i | input | 1 | Receive engine delivers a byte |
| rx_data_i | input | DATA_W | Received byte |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| lcr_o | output | LCR_W | Line-control byte |
| divisor_o | output | DIV_W | Baud divisor |

## Verification
The bench fills the transmit FIFO to capacity and then writes once more. A design that let the extra write in would overwrite the oldest byte or wrap its count, and the drained order would show it. The bench drains the receive FIFO past empty and expects zero with no spurious later data, because a design that underflows would hand back stale bytes. It also reads the data address with the latch bit set while received data is waiting. A design that popped anyway would lose that byte. Finally it writes the low divisor byte through the latched data address and checks that the high byte survives. A design that treated that access as a full 16-bit write would clear divisor[15:8].

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
  localparam int unsigned LCR_W    = 8;
  localparam int unsigned DIV_W    = 16;
  localparam int unsigned DLAB_BIT = 7;

  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_LCR  = 3'd1,
    A_DIV  = 3'd2,
    A_STAT = 3'd3
  } reg_addr_e;

  // last member is bit 0
  typedef struct packed {
    logic rx_full;
    logic rx_empty;
    logic tx_full;
    logic tx_empty;
  } stat_t;
endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full/empty gate requests: no overflow, no underflow
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = empty_o ? '0 : mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regfile_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lcr_we_i,
  input  logic             div_lo_we_i,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic [LCR_W-1:0] lcr_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int unsigned LO_W = 8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_o <= '0;
      div_o <= '0;
    end else begin
      if (lcr_we_i) lcr_o <= wdata_i[LCR_W-1:0];
      if (div_we_i)
        div_o <= wdata_i;
      else if (div_lo_we_i)
        div_o[LO_W-1:0] <= wdata_i[LO_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_empty_o,
  output logic              tx_full_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic [LCR_W-1:0]  lcr_o,
  output logic [DIV_W-1:0]  divisor_o
);
  logic              wr, rd, dlab;
  logic              hit_data, hit_lcr, hit_div, hit_stat;
  logic              tx_push, rx_pop;
  logic [DATA_W-1:0] rx_head;
  logic [BUS_W-1:0]  rd_next;
  stat_t             stat;

  assign wr       = req_i & we_i;
  assign rd       = req_i & ~we_i;
  assign hit_data = (addr_i == ADDR_W'(A_DATA));
  assign hit_lcr  = (addr_i == ADDR_W'(A_LCR));
  assign hit_div  = (addr_i == ADDR_W'(A_DIV));
  assign hit_stat = (addr_i == ADDR_W'(A_STAT));
  assign dlab     = lcr_o[DLAB_BIT];
  assign tx_push  = wr & hit_data & ~dlab;
  assign rx_pop   = rd & hit_data & ~dlab;

  uart_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lcr_we_i   (wr & hit_lcr),
    .div_lo_we_i(wr & hit_data & dlab),
    .div_we_i   (wr & hit_div),
    .wdata_i    (wdata_i[DIV_W-1:0]),
    .lcr_o      (lcr_o),
    .div_o      (divisor_o)
  );

  uart_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (tx_push),
    .wdata_i(wdata_i[DATA_W-1:0]),
    .pop_i  (tx_pop_i),
    .rdata_o(tx_data_o),
    .full_o (tx_full_o),
    .empty_o(tx_empty_o)
  );

  uart_sync_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (rx_push_i),
    .wdata_i(rx_data_i),
    .pop_i  (rx_pop),
    .rdata_o(rx_head),
    .full_o (rx_full_o),
    .empty_o(rx_empty_o)
  );

  assign stat = '{rx_full: rx_full_o, rx_empty: rx_empty_o,
                  tx_full: tx_full_o, tx_empty: tx_empty_o};

  always_comb begin
    rd_next = '0;
    unique case (1'b1)
      hit_data: rd_next[DATA_W-1:0] = dlab ? divisor_o[DATA_W-1:0] : rx_head;
      hit_lcr:  rd_next[LCR_W-1:0]  = lcr_o;
      hit_div:  rd_next[DIV_W-1:0]  = divisor_o;
      hit_stat: rd_next[$bits(stat_t)-1:0] = stat;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_next;
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              tx_pop_i,
  input logic              tx_empty_o,
  input logic              tx_full_o,
  input logic              rx_empty_o,
  input logic [7:0]        lcr_o,
  input logic [15:0]       divisor_o
);
  logic data_wr, data_rd, lcr_wr;
  assign data_wr = req_i & we_i & (addr_i == '0);
  assign data_rd = req_i & ~we_i & (addr_i == '0);
  assign lcr_wr  = req_i & we_i & (addr_i == ADDR_W'(1));

  // R2
  dlab_div_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr & lcr_o[7] |=> divisor_o[7:0] == $past(wdata_i[7:0]) &&
                           divisor_o[15:8] == $past(divisor_o[15:8]));
  // R2
  dlab_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr & lcr_o[7] & ~tx_pop_i |=> tx_empty_o == $past(tx_empty_o));
  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr & ~lcr_o[7] & tx_full_o & ~tx_pop_i |=> tx_full_o);
  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd & ~lcr_o[7] & rx_empty_o |=> rdata_o == '0);
  // R8
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUS_W-1:16] == '0);
  // R11
  lcr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcr_wr |=> lcr_o == $past(wdata_i[7:0]));
endmodule

bind uart_regfile uart_regfile_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .tx_pop_i  (tx_pop_i),
  .tx_empty_o(tx_empty_o),
  .tx_full_o (tx_full_o),
  .rx_empty_o(rx_empty_o),
  .lcr_o     (lcr_o),
  .divisor_o (divisor_o)
);

// File: tb/sim_uart_regfile.sv
module sim_uart_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [7:0]  tx_data, lcr;
  logic        tx_empty, tx_full, rx_full, rx_empty;
  logic [15:0] divisor;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  localparam logic [2:0] A_DATA = 3'd0, A_LCR = 3'd1, A_DIV = 3'd2, A_STAT = 3'd3;

  always #10 clk = ~clk;  // 50 MHz

  uart_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .tx_empty_o(tx_empty), .tx_full_o(tx_full), .rx_push_i(rx_push),
    .rx_data_i(rx_data), .rx_full_o(rx_full), .rx_empty_o(rx_empty),
    .lcr_o(lcr), .divisor_o(divisor)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare registered read data against the scoreboard
  always @(posedge clk) rd_seen <= req & ~we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 32'h0);
    check("R1 divisor", {16'h0, divisor}, 32'h0);
    check("R1 lcr", {24'h0, lcr}, 32'h0);
    check("R1 flags", {28'h0, rx_full, rx_empty, tx_full, tx_empty}, 32'h5);
    bus_rd(A_STAT, 32'h5, "R1 R9 status after reset");

    // R11 line control, latch bit set
    bus_wr(A_LCR, 32'hFFFF_FF80);
    check("R11 lcr_o", {24'h0, lcr}, 32'h80);
    bus_rd(A_LCR, 32'h80, "R11 R7 lcr readback");
    // R2 R7 low divisor byte through data address
    bus_wr(A_DATA, 32'hFFFF_FFA5);
    check("R2 divisor low", {16'h0, divisor}, 32'h00A5);
    check("R2 no tx push", {31'h0, tx_empty}, 32'h1);
    bus_rd(A_DATA, 32'hA5, "R2 R7 data read under latch");
    // R8 direct divisor
    bus_wr(A_DIV, 32'hABCD_1234);
    bus_rd(A_DIV, 32'h1234, "R8 divisor readback");
    bus_wr(A_DATA, 32'h77);
    check("R2 high byte kept", {16'h0, divisor}, 32'h1277);

    // latch clear
    bus_wr(A_LCR, 32'h03);
    bus_rd(A_DIV, 32'h1277, "R8 divisor with latch clear");
    bus_wr(A_DATA, 32'hDEAD_0011);
    check("R3 R7 tx head", {24'h0, tx_data}, 32'h11);
    check("R3 tx not empty", {31'h0, tx_empty}, 32'h0);
    check("R3 divisor untouched", {16'h0, divisor}, 32'h1277);
    for (int i = 1; i < 8; i++) bus_wr(A_DATA, 32'h20 + i);
    check("R4 tx full", {31'h0, tx_full}, 32'h1);
    bus_rd(A_STAT, 32'h6, "R9 status tx full");
    bus_wr(A_DATA, 32'h99);  // dropped
    check("R4 head after drop", {24'h0, tx_data}, 32'h11);
    pop_tx();
    for (int i = 1; i < 8; i++) begin
      check("R3 R4 tx order", {24'h0, tx_data}, 32'h20 + i);
      pop_tx();
    end
    check("R4 tx empty after 8", {31'h0, tx_empty}, 32'h1);
    pop_tx();  // R10 ignored
    check("R10 tx still empty", {31'h0, tx_empty}, 32'h1);
    bus_wr(A_DATA, 32'h55);
    check("R10 tx head after empty pop", {24'h0, tx_data}, 32'h55);
    pop_tx();

    // receive path
    bus_rd(A_DATA, 32'h0, "R6 empty rx read");
    check("R6 rx still empty", {31'h0, rx_empty}, 32'h1);
    for (int i = 0; i < 8; i++) push_rx(8'h80 + 8'(i));
    check("R10 rx full", {31'h0, rx_full}, 32'h1);
    bus_rd(A_STAT, 32'h9, "R9 status rx full");
    push_rx(8'hEE);  // R10 dropped
    for (int i = 0; i < 8; i++) bus_rd(A_DATA, 32'h80 + i, "R5 R10 rx order");
    bus_rd(A_DATA, 32'h0, "R6 read past empty");
    check("R6 rx empty", {31'h0, rx_empty}, 32'h1);

    // R2 latched read must not pop
    push_rx(8'h3C);
    bus_wr(A_LCR, 32'h80);
    bus_rd(A_DATA, 32'h77, "R2 latched read returns divisor");
    check("R2 rx not popped", {31'h0, rx_empty}, 32'h0);
    bus_wr(A_LCR, 32'h00);
    bus_rd(A_DATA, 32'h3C, "R5 single pop");
    bus_rd(A_DATA, 32'h0, "R5 popped once only");
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule